// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the front end of a small NAND flash device model. On every write strobe it samples an 8-bit I/O bus together with a command-latch qualifier, an address-latch qualifier and an active-low chip enable. It decodes command opcodes, collects address bytes into a 40-bit address register with the least significant byte first, and counts the address cycles. When a command is complete it raises a single-cycle execute pulse. The pulse carries the operation, the address and a column offset to the datapath that owns the array.

Some opcodes take effect as soon as the command byte is latched. Others wait for a specific address cycle, and that cycle depends on the opcode and on the device class. Two read variants are folded into the plain read with a preset column offset. Small-page and large-page behaviour, page size and device density are elaboration parameters, so one source serves every device class.

Top module: `nand_cmd_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) no pulse is raised, the current command is read (0x00), and both the address and the cycle count are zero. Five address bytes with no command therefore launch a read on a large-page device above 1 Gbit.
- R2: A strobe changes nothing unless `ce_n` is low. A command byte is taken only when `cle` is high, and an address byte only when `ale` is high.
- R3: Opcodes 0x70, 0x10, 0x60, 0xD0, 0x35, 0xE0 and 0xFF raise `exec_vld` for exactly one clock, starting at the edge after the strobe, with `exec_op` equal to the opcode.
- R4: Opcode 0x01 is reported as a read (0x00) with column offset 0x100. Opcode 0x50 is reported as a read with a column offset equal to `PAGE_BYTES`. Opcode 0x00 sets the offset to zero. The offset appears on `exec_col`.
- R5: Address byte number n (counting from 0) is written to `exec_addr` bits [8n+7:8n]. A byte that arrives when five bytes are already held is dropped, changes no address bit and causes no launch.
- R6: Read ID (0x90) launches on its first address byte, and only on that byte.
- R7: Read (0x00) and program setup (0x80) launch on address byte 3 on small-page devices, on byte 4 on large-page devices of 1024 Mbit or less, and on byte 5 on larger large-page devices.
- R8: On a large-page device, 0x30 received while the current command is 0x00 is ignored completely, and the cycle count continues. On a small-page device 0x30 is latched as an ordinary command.
- R9: On a large-page device, 0x05 clears address bits [15:0] and restarts the cycle count. It leaves the current command unchanged and raises no pulse.
- R10: Every latched command except 0xE0 restarts the address cycle count. 0xE0 keeps the count.
- R11: On erase confirm (0xD0), the held address is shifted left by 16 bits on large-page devices and by 8 bits on small-page devices. The shifted value is reported and also kept.
- R12: When `cle` and `ale` are both high on one strobe, the command takes effect first, and the same byte is then taken as an address byte using the resulting count. An opcode that launches on the command byte takes priority as the reported operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write strobe; the bus is sampled on edges where it is high |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| io_din | input | 8 | I/O bus byte |
| exec_vld | output | 1 | One-cycle execute pulse |
| exec_op | output | 8 | Operation to execute |
| exec_addr | output | 40 | Address at the time of launch |
| exec_col | output | $clog2(PAGE_BYTES)+1 | Column offset preset by the read variant |

## Verification
Command decoding and address capture can act on the same strobe: either because both qualifiers are high, or because a command rewrites the address that the byte then lands in. The bench drives strobes with both qualifiers high, for an opcode that launches on the address byte (0x90) and for one that launches on the command byte (0x70). It checks that the reported operation and the reported address both reflect the command first and the byte second. The 0x05 and 0xD0 cases are handled the same way: the address a later 0xE0 reports shows whether the rewrite and the next capture were applied in the right order.

// File: rtl/nseq_pkg.sv
// Package: opcode constants and decode enums shared by the sequencer.
// Assumes an 8-bit command bus; opcodes are compared as raw bytes.
package nseq_pkg;
    localparam logic [7:0] OPC_READ       = 8'h00;
    localparam logic [7:0] OPC_READ_HI    = 8'h01;
    localparam logic [7:0] OPC_READ_SPARE = 8'h50;
    localparam logic [7:0] OPC_READ_GO    = 8'h30;
    localparam logic [7:0] OPC_READ_NOSER = 8'h35;
    localparam logic [7:0] OPC_COL_CHG    = 8'h05;
    localparam logic [7:0] OPC_COL_GO     = 8'hE0;
    localparam logic [7:0] OPC_IDENT      = 8'h90;
    localparam logic [7:0] OPC_RESET      = 8'hFF;
    localparam logic [7:0] OPC_PROG       = 8'h80;
    localparam logic [7:0] OPC_PROG_GO    = 8'h10;
    localparam logic [7:0] OPC_PROG_CACHE = 8'h15;
    localparam logic [7:0] OPC_ERASE      = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OPC_STATUS     = 8'h70;
    localparam logic [7:0] OPC_COPY       = 8'h85;

    // How a command byte is treated
    typedef enum logic [1:0] {
        CB_LATCH  = 2'd0,
        CB_IGNORE = 2'd1,
        CB_COLUMN = 2'd2
    } cmd_kind_e;

    // Column offset update selected by a command byte
    typedef enum logic [1:0] {
        OFF_KEEP  = 2'd0,
        OFF_ZERO  = 2'd1,
        OFF_HALF  = 2'd2,
        OFF_SPARE = 2'd3
    } off_sel_e;
endpackage

// File: rtl/nseq_cmd_decode.sv
// Module: combinational decode of one command byte against the current command.
// Classifies the byte (latch / ignore / column restart), rewrites read
// variants into a plain read with an offset selection, and flags immediate
// launch, count retention and erase-confirm shifting.
// Assumes it is evaluated only for strobes qualified as command cycles.
module nseq_cmd_decode
    import nseq_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b1
) (
    input  logic [7:0] byte_i,
    input  logic [7:0] cur_cmd_i,
    output cmd_kind_e  kind_o,
    output logic [7:0] new_cmd_o,
    output off_sel_e   off_sel_o,
    output logic       exec_now_o,
    output logic       keep_cnt_o,
    output logic       erase_o
);
    // Classify the byte and derive its effects
    always_comb begin
        kind_o     = CB_LATCH;
        new_cmd_o  = byte_i;
        off_sel_o  = OFF_KEEP;
        exec_now_o = 1'b0;
        keep_cnt_o = 1'b0;
        erase_o    = 1'b0;
        if (LARGE_PAGE && cur_cmd_i == OPC_READ && byte_i == OPC_READ_GO) begin
            kind_o = CB_IGNORE;
        end else if (LARGE_PAGE && byte_i == OPC_COL_CHG) begin
            kind_o = CB_COLUMN;
        end else begin
            case (byte_i)
                OPC_READ:       off_sel_o = OFF_ZERO;
                OPC_READ_HI: begin
                    off_sel_o = OFF_HALF;
                    new_cmd_o = OPC_READ;
                end
                OPC_READ_SPARE: begin
                    off_sel_o = OFF_SPARE;
                    new_cmd_o = OPC_READ;
                end
                default: ;
            endcase
            case (new_cmd_o)
                OPC_STATUS, OPC_PROG_GO, OPC_ERASE, OPC_ERASE_GO,
                OPC_READ_NOSER, OPC_COL_GO, OPC_RESET: exec_now_o = 1'b1;
                default: ;
            endcase
            keep_cnt_o = (new_cmd_o == OPC_COL_GO);
            erase_o    = (new_cmd_o == OPC_ERASE_GO);
        end
    end
endmodule

// File: rtl/nseq_addr_gather.sv
// Module: address register and address-cycle counter.
// Within one strobe it applies command effects first (column clear, count
// restart, row shift) and then stores the address byte at the resulting count.
// Assumes ADDR_BYTES address cycles fill the register exactly.
module nseq_addr_gather #(
    parameter int ADDR_BYTES = 5,
    parameter int COL_BITS   = 16,
    parameter int ROW_SHIFT  = 16,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_clr_i,
    input  logic              clr_cnt_i,
    input  logic              row_shift_i,
    input  logic              byte_we_i,
    input  logic [7:0]        byte_i,
    output logic [ADDR_W-1:0] addr_nx_o,
    output logic [CNT_W-1:0]  cnt_nx_o,
    output logic [CNT_W-1:0]  cnt_q_o,
    output logic              taken_o
);
    localparam logic [ADDR_W-1:0] COL_MASK =
        {{(ADDR_W - COL_BITS){1'b0}}, {COL_BITS{1'b1}}};

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    // Next address and count: command effects, then the address byte
    always_comb begin
        addr_nx_o = addr_q;
        cnt_nx_o  = cnt_q;
        if (col_clr_i) begin
            addr_nx_o = addr_nx_o & ~COL_MASK;
            cnt_nx_o  = '0;
        end
        if (clr_cnt_i) cnt_nx_o = '0;
        if (row_shift_i) addr_nx_o = addr_nx_o << ROW_SHIFT;
        taken_o = byte_we_i && (cnt_nx_o < CNT_W'(ADDR_BYTES));
        if (taken_o) begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (cnt_nx_o == CNT_W'(k)) addr_nx_o[8*k +: 8] = byte_i;
            end
            cnt_nx_o = cnt_nx_o + 1'b1;
        end
    end

    // State update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_nx_o;
            cnt_q  <= cnt_nx_o;
        end
    end

    assign cnt_q_o = cnt_q;
endmodule

// File: rtl/nseq_launch.sv
// Module: decides whether an accepted address byte completes a command.
// Read ID completes on cycle 1; read and program setup complete on the
// class-dependent LAUNCH_CYC. Assumes cmd_i is the command after this strobe.
module nseq_launch
    import nseq_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int LAUNCH_CYC = 5
) (
    input  logic [7:0]       cmd_i,
    input  logic             taken_i,
    input  logic [CNT_W-1:0] cnt_nx_i,
    output logic             fire_o
);
    // Launch on the address cycle that completes the command
    always_comb begin
        fire_o = 1'b0;
        if (taken_i) begin
            if (cmd_i == OPC_IDENT && cnt_nx_i == CNT_W'(1)) fire_o = 1'b1;
            if ((cmd_i == OPC_READ || cmd_i == OPC_PROG) &&
                cnt_nx_i == CNT_W'(LAUNCH_CYC)) fire_o = 1'b1;
        end
    end
endmodule

// File: rtl/nand_cmd_seq.sv
// Module: NAND command and address sequencer (top).
// Samples the I/O bus on write strobes, tracks the current command and the
// column offset, and emits a registered one-cycle execute pulse with payload.
// Assumes LAUNCH_CYC <= ADDR_BYTES and an 8-bit bus.
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter bit LARGE_PAGE   = 1'b1,
    parameter int PAGE_BYTES   = 2048,
    parameter int DENSITY_MBIT = 2048,
    parameter int ADDR_BYTES   = 5,
    localparam int ADDR_W      = 8 * ADDR_BYTES,
    localparam int OFF_W       = $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic [7:0]        io_din,
    output logic              exec_vld,
    output logic [7:0]        exec_op,
    output logic [ADDR_W-1:0] exec_addr,
    output logic [OFF_W-1:0]  exec_col
);
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int COL_BITS   = LARGE_PAGE ? 16 : 8;
    localparam int LAUNCH_CYC = LARGE_PAGE ? ((DENSITY_MBIT <= 1024) ? 4 : 5) : 3;

    logic [7:0]        cmd_q, cmd_nx, dec_cmd;
    logic [OFF_W-1:0]  off_q, off_nx;
    cmd_kind_e         dec_kind;
    off_sel_e          dec_off;
    logic              dec_now, dec_keep, dec_erase;
    logic              cmd_ok, adr_ok, latch, col_clr;
    logic [ADDR_W-1:0] addr_nx;
    logic [CNT_W-1:0]  cnt_nx, cnt_q;
    logic              taken, fire_adr, fire;

    assign cmd_ok  = wr_stb && !ce_n && cle;
    assign adr_ok  = wr_stb && !ce_n && ale;
    assign latch   = cmd_ok && (dec_kind == CB_LATCH);
    assign col_clr = cmd_ok && (dec_kind == CB_COLUMN);
    assign cmd_nx  = latch ? dec_cmd : cmd_q;

    nseq_cmd_decode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
        .byte_i     (io_din),
        .cur_cmd_i  (cmd_q),
        .kind_o     (dec_kind),
        .new_cmd_o  (dec_cmd),
        .off_sel_o  (dec_off),
        .exec_now_o (dec_now),
        .keep_cnt_o (dec_keep),
        .erase_o    (dec_erase)
    );

    nseq_addr_gather #(
        .ADDR_BYTES (ADDR_BYTES),
        .COL_BITS   (COL_BITS),
        .ROW_SHIFT  (COL_BITS)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_clr_i   (col_clr),
        .clr_cnt_i   (latch && !dec_keep),
        .row_shift_i (latch && dec_erase),
        .byte_we_i   (adr_ok),
        .byte_i      (io_din),
        .addr_nx_o   (addr_nx),
        .cnt_nx_o    (cnt_nx),
        .cnt_q_o     (cnt_q),
        .taken_o     (taken)
    );

    nseq_launch #(.CNT_W(CNT_W), .LAUNCH_CYC(LAUNCH_CYC)) u_launch (
        .cmd_i    (cmd_nx),
        .taken_i  (taken),
        .cnt_nx_i (cnt_nx),
        .fire_o   (fire_adr)
    );

    assign fire = (latch && dec_now) || fire_adr;

    // Column offset chosen by the latched read variant
    always_comb begin
        off_nx = off_q;
        if (latch) begin
            case (dec_off)
                OFF_ZERO:  off_nx = '0;
                OFF_HALF:  off_nx = OFF_W'(256);
                OFF_SPARE: off_nx = OFF_W'(PAGE_BYTES);
                default:   off_nx = off_q;
            endcase
        end
    end

    // Current command and offset registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= OPC_READ;
            off_q <= '0;
        end else begin
            cmd_q <= cmd_nx;
            off_q <= off_nx;
        end
    end

    // Registered execute pulse and payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_vld  <= 1'b0;
            exec_op   <= '0;
            exec_addr <= '0;
            exec_col  <= '0;
        end else begin
            exec_vld <= fire;
            if (fire) begin
                exec_op   <= cmd_nx;
                exec_addr <= addr_nx;
                exec_col  <= off_nx;
            end
        end
    end
endmodule

// File: rtl/nseq_checker.sv
// Module: protocol checker bound to nand_cmd_seq.
// Observes ports plus the command and count registers.
module nseq_checker #(
    parameter int ADDR_W     = 40,
    parameter int ADDR_BYTES = 5,
    parameter int CNT_W      = 3,
    parameter int COL_BITS   = 16,
    parameter int LAUNCH_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              ce_n,
    input logic              exec_vld,
    input logic [7:0]        exec_op,
    input logic [ADDR_W-1:0] exec_addr,
    input logic [7:0]        cmd_q,
    input logic [CNT_W-1:0]  cnt_q
);
    logic rst_prev;

    // Remember reset from the previous edge
    always_ff @(posedge clk) rst_prev <= rst_n;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_prev |-> (cmd_q == 8'h00 && cnt_q == '0 && !exec_vld));

    a_r2_gated_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld |-> $past(wr_stb && !ce_n));

    a_r4_no_alias_op: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld |-> (exec_op != 8'h01 && exec_op != 8'h50));

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));

    a_r6_ident_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && exec_op == 8'h90) |-> cnt_q == CNT_W'(1));

    a_r7_launch_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && (exec_op == 8'h00 || exec_op == 8'h80)) |-> cnt_q == CNT_W'(LAUNCH_CYC));

    a_r11_erase_row: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && exec_op == 8'hD0) |-> (exec_addr[COL_BITS-1:0] == '0 && cnt_q == '0));
endmodule

bind nand_cmd_seq nseq_checker #(
    .ADDR_W     (ADDR_W),
    .ADDR_BYTES (ADDR_BYTES),
    .CNT_W      (CNT_W),
    .COL_BITS   (COL_BITS),
    .LAUNCH_CYC (LAUNCH_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .ce_n      (ce_n),
    .exec_vld  (exec_vld),
    .exec_op   (exec_op),
    .exec_addr (exec_addr),
    .cmd_q     (cmd_q),
    .cnt_q     (cnt_q)
);

// File: tb/sim_nand_cmd_seq.sv
// Directed bench: u0 large page 2048 Mbit, u1 small page, u2 large page 1024 Mbit.
module sim_nand_cmd_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0, ce_n = 1'b0, cle = 1'b0, ale = 1'b0;
    logic [7:0] io_din = 8'h00;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic v0, v1, v2;
    logic [7:0] op0, op1, op2;
    logic [39:0] a0, a1, a2;
    logic [11:0] c0, c2;
    logic [9:0] c1;

    always #5 clk = ~clk;

    nand_cmd_seq u0 (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .cle(cle),
        .ale(ale), .io_din(io_din), .exec_vld(v0), .exec_op(op0), .exec_addr(a0), .exec_col(c0));
    nand_cmd_seq #(.LARGE_PAGE(1'b0), .PAGE_BYTES(512), .DENSITY_MBIT(128)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .cle(cle),
        .ale(ale), .io_din(io_din), .exec_vld(v1), .exec_op(op1), .exec_addr(a1), .exec_col(c1));
    nand_cmd_seq #(.LARGE_PAGE(1'b1), .PAGE_BYTES(2048), .DENSITY_MBIT(1024)) u2 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .cle(cle),
        .ale(ale), .io_din(io_din), .exec_vld(v2), .exec_op(op2), .exec_addr(a2), .exec_col(c2));

    task automatic chk(string tag, logic v, logic [7:0] op, logic [39:0] a,
                       logic ev, logic [7:0] eop, logic [39:0] ea);
        checks++;
        if (v !== ev || (ev && (op !== eop || a !== ea))) begin
            errors++;
            $display("FAIL %s: got vld=%b op=%h addr=%h, expected vld=%b op=%h addr=%h",
                     tag, v, op, a, ev, eop, ea);
        end
    endtask

    task automatic chk_col(string tag, logic [11:0] got, logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got col=%h expected col=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One strobe; outputs are sampled at the following falling edge
    task automatic stb(logic c, logic a, logic [7:0] b, logic ce = 1'b0);
        @(negedge clk);
        ce_n = ce; cle = c; ale = a; io_din = b; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 idle after reset", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'h11); stb(0, 1, 8'h22); stb(0, 1, 8'h33); stb(0, 1, 8'h44);
        chk("R1 no early launch", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'h55);
        chk("R1 R5 read from reset state", v0, op0, a0, 1'b1, 8'h00, 40'h5544332211);
        chk_col("R1 offset zero", c0, 12'h000);
        @(negedge clk);
        chk("R3 pulse one cycle", v0, op0, a0, 1'b0, 8'h00, 40'h0);
    endtask

    task automatic t_gate();
        do_reset();
        stb(1, 0, 8'h70, 1'b1);
        chk("R2 ce high blocks command", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 0, 8'h70);
        chk("R2 no qualifier blocks command", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'hAA, 1'b1);
        stb(1, 0, 8'hE0);
        chk("R2 ce high blocks address", v0, op0, a0, 1'b1, 8'hE0, 40'h0);
    endtask

    task automatic t_immediate();
        logic [7:0] ops [7] = '{8'h70, 8'h10, 8'h60, 8'hD0, 8'h35, 8'hE0, 8'hFF};
        do_reset();
        foreach (ops[i]) begin
            stb(1, 0, ops[i]);
            chk($sformatf("R3 immediate %h", ops[i]), v0, op0, a0, 1'b1, ops[i], 40'h0);
            @(negedge clk);
            chk("R3 single cycle", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        end
    endtask

    task automatic t_offset();
        do_reset();
        stb(1, 0, 8'h50);
        stb(0, 1, 8'h01); stb(0, 1, 8'h00); stb(0, 1, 8'h00); stb(0, 1, 8'h00); stb(0, 1, 8'h00);
        chk("R4 spare read as read", v0, op0, a0, 1'b1, 8'h00, 40'h1);
        chk_col("R4 spare offset", c0, 12'd2048);
        stb(1, 0, 8'h01);
        stb(0, 1, 8'h02); stb(0, 1, 8'h00); stb(0, 1, 8'h00); stb(0, 1, 8'h00); stb(0, 1, 8'h00);
        chk("R4 half read as read", v0, op0, a0, 1'b1, 8'h00, 40'h2);
        chk_col("R4 half offset", c0, 12'h100);
        stb(1, 0, 8'h00);
        stb(0, 1, 8'h03); stb(0, 1, 8'h00); stb(0, 1, 8'h00); stb(0, 1, 8'h00); stb(0, 1, 8'h00);
        chk_col("R4 plain read clears offset", c0, 12'h000);
    endtask

    task automatic t_overflow();
        do_reset();
        stb(1, 0, 8'h00);
        stb(0, 1, 8'h11); stb(0, 1, 8'h22); stb(0, 1, 8'h33); stb(0, 1, 8'h44); stb(0, 1, 8'h55);
        stb(0, 1, 8'h66);
        chk("R5 sixth byte no launch", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(1, 0, 8'hE0);
        chk("R5 sixth byte dropped", v0, op0, a0, 1'b1, 8'hE0, 40'h5544332211);
    endtask

    task automatic t_ident();
        do_reset();
        stb(1, 0, 8'h90);
        chk("R6 no launch on command", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'hAB);
        chk("R6 read id launch", v0, op0, a0, 1'b1, 8'h90, 40'hAB);
        stb(0, 1, 8'hCD);
        chk("R6 second byte quiet", v0, op0, a0, 1'b0, 8'h00, 40'h0);
    endtask

    task automatic t_class();
        do_reset();
        stb(1, 0, 8'h80);
        stb(0, 1, 8'h01); stb(0, 1, 8'h02); stb(0, 1, 8'h03);
        chk("R7 small page cycle 3", v1, op1, a1, 1'b1, 8'h80, 40'h030201);
        chk("R7 large 1G not yet", v2, op2, a2, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'h04);
        chk("R7 large 1G cycle 4", v2, op2, a2, 1'b1, 8'h80, 40'h04030201);
        chk("R7 large 2G not yet", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        chk("R7 small page once", v1, op1, a1, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'h05);
        chk("R7 large 2G cycle 5", v0, op0, a0, 1'b1, 8'h80, 40'h0504030201);
    endtask

    task automatic t_confirm_ignored();
        do_reset();
        stb(1, 0, 8'h00);
        stb(0, 1, 8'h11); stb(0, 1, 8'h22);
        stb(1, 0, 8'h30);
        chk("R8 large page ignores 30", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'h33); stb(0, 1, 8'h44);
        chk("R8 count kept", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'h55);
        chk("R8 read launch after 30", v0, op0, a0, 1'b1, 8'h00, 40'h5544332211);
        chk("R8 small page latched 30", v1, op1, a1, 1'b0, 8'h00, 40'h0);
    endtask

    task automatic t_column();
        do_reset();
        stb(1, 0, 8'h00);
        stb(0, 1, 8'h11); stb(0, 1, 8'h22); stb(0, 1, 8'h33); stb(0, 1, 8'h44); stb(0, 1, 8'h55);
        stb(1, 0, 8'h05);
        chk("R9 column change quiet", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(1, 0, 8'hE0);
        chk("R9 column bits cleared", v0, op0, a0, 1'b1, 8'hE0, 40'h5544330000);
        do_reset();
        stb(1, 0, 8'h80);
        stb(0, 1, 8'h11); stb(0, 1, 8'h22);
        stb(1, 0, 8'h05);
        stb(0, 1, 8'hAA); stb(0, 1, 8'hBB); stb(0, 1, 8'hCC);
        chk("R9 count restarted", v0, op0, a0, 1'b0, 8'h00, 40'h0);
        stb(0, 1, 8'hDD); stb(0, 1, 8'hEE);
        chk("R9 command kept", v0, op0, a0, 1'b1, 8'h80, 40'hEEDDCCBBAA);
    endtask

    task automatic t_count_keep();
        do_reset();
        stb(1, 0, 8'h80);
        stb(0, 1, 8'h11); stb(0, 1, 8'h22);
        stb(1, 0, 8'hE0);
        chk("R10 E0 payload", v0, op0, a0, 1'b1, 8'hE0, 40'h2211);
        stb(0, 1, 8'h33);
        stb(1, 0, 8'hE0);
        chk("R10 E0 keeps count", v0, op0, a0, 1'b1, 8'hE0, 40'h332211);
        stb(1, 0, 8'h60);
        stb(0, 1, 8'h44);
        stb(1, 0, 8'hE0);
        chk("R10 other command restarts count", v0, op0, a0, 1'b1, 8'hE0, 40'h332244);
    endtask

    task automatic t_erase();
        do_reset();
        stb(1, 0, 8'h60);
        stb(0, 1, 8'h12); stb(0, 1, 8'h34); stb(0, 1, 8'h56);
        stb(1, 0, 8'hD0);
        chk("R11 large page row shift", v0, op0, a0, 1'b1, 8'hD0, 40'h5634120000);
        chk("R11 small page row shift", v1, op1, a1, 1'b1, 8'hD0, 40'h0056341200);
        stb(1, 0, 8'hE0);
        chk("R11 shifted address kept", v0, op0, a0, 1'b1, 8'hE0, 40'h5634120000);
    endtask

    task automatic t_both();
        do_reset();
        stb(1, 1, 8'h90);
        chk("R12 command then byte", v0, op0, a0, 1'b1, 8'h90, 40'h90);
        stb(1, 1, 8'h70);
        chk("R12 immediate wins", v0, op0, a0, 1'b1, 8'h70, 40'h70);
        stb(0, 1, 8'h21);
        stb(1, 0, 8'hE0);
        chk("R12 byte counted after command", v0, op0, a0, 1'b1, 8'hE0, 40'h2170);
    endtask

    initial begin
        t_reset();
        t_gate();
        t_immediate();
        t_offset();
        t_overflow();
        t_ident();
        t_class();
        t_confirm_ignored();
        t_column();
        t_count_keep();
        t_erase();
        t_both();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule